// File: doc/BRIEF.md
# CPU Bus Glue and Address Decoder

This block is the glue logic of a small single-board computer built around an 8-bit-data, 20-bit-address CPU. It watches the address, the address strobe, the data strobe, the read/write line and the three function-code lines. From these it produces active-low chip selects for a 256 KiB flash ROM, a 512 KiB SRAM, a polled serial port and an 8-bit debug LED register. It also produces a shared read enable and a shared write enable for those devices.

The data-transfer acknowledge is tied active, so every bus cycle completes with no wait states. The interrupt priority lines back to the CPU are held inactive, because the system only polls and has no interrupts. The LED register lives inside the block and is loaded from the data bus.

Address map, decoded on A19..A16:
- RAM: 0x00000–0x7FFFF (A19 = 0).
- Serial port: 0x80000–0x8FFFF.
- LED register: 0x90000–0x9FFFF.
- Unmapped: 0xA0000–0xBFFFF.
- ROM: 0xC0000–0xFFFFF (A19 = A18 = 1).

Top module: `cpu_glue`

## Requirements
- R1: `ramCsN` is 0 exactly when A19 = 0, `asN` = 0 and `fc` is not 3'b111.
- R2: `romCsN` is 0 exactly when A19 = 1, A18 = 1, `asN` = 0 and `fc` is not 3'b111.
- R3: `serCsN` is 0 exactly for A19..A16 = 4'h8, and `ledCsN` is 0 exactly for A19..A16 = 4'h9, each under the same strobe and function-code qualification. Addresses with A19..A16 = 4'hA or 4'hB select nothing.
- R4: While `asN` = 1, all four chip selects are 1, whatever the address shows.
- R5: While `fc` = 3'b111 (interrupt acknowledge), all four chip selects are 1.
- R6: At most one chip select is 0 in any cycle.
- R7: `readEnN` is 0 exactly when `rdWr` = 1, `dsN` = 0 and some chip select is 0.
- R8: `writeEnN` is 0 exactly when `rdWr` = 0, `dsN` = 0 and the RAM, serial or LED select is 0. A write into the ROM region never asserts it.
- R9: `dtackN` is always 0, and `iplN` is always 3'b111.
- R10: On a rising `clk` edge where `ledCsN` = 0, `rdWr` = 0 and `dsN` = 0, `ledOut` takes `dataIn`. On every other edge, `ledOut` holds its value.
- R11: While `rstN` = 0, `ledOut` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| addr | input | 20 | CPU address A19..A0 |
| asN | input | 1 | Address strobe, active low |
| dsN | input | 1 | Data strobe, active low |
| rdWr | input | 1 | 1 = read, 0 = write |
| fc | input | 3 | CPU function code |
| dataIn | input | 8 | CPU data bus, used for LED writes |
| romCsN | output | 1 | ROM chip select |
| ramCsN | output | 1 | RAM chip select |
| serCsN | output | 1 | Serial port chip select |
| ledCsN | output | 1 | LED register select |
| readEnN | output | 1 | Output enable to devices |
| writeEnN | output | 1 | Write enable to writable devices |
| dtackN | output | 1 | Data-transfer acknowledge |
| iplN | output | 3 | Interrupt priority to CPU |
| ledOut | output | 8 | Debug LED register |

## Verification
On every clock, the assertions check these properties:
- An idle address strobe or an interrupt-acknowledge cycle keeps all selects inactive.
- Selects are mutually exclusive.
- The ROM region never produces a write enable.
- A read enable only appears with a read cycle and the data strobe asserted.
- The LED register loads or holds according to its strobe.

Only the bench sweep can show that each region opens at exactly the right address nibble. The sweep covers every address nibble under every strobe, direction and function-code combination. It also shows the exact enable polarity in the unmapped hole, and that reset clears a register that was already loaded.

// File: rtl/glue_pkg.sv
package glue_pkg;

  localparam int ADDR_W      = 20;
  localparam int DATA_W      = 8;
  localparam int NUM_REGIONS = 4;

  // region indices
  localparam int RGN_RAM = 0;
  localparam int RGN_ROM = 1;
  localparam int RGN_SER = 2;
  localparam int RGN_LED = 3;

  localparam logic [2:0] FC_INTACK = 3'b111;

  // a region hits when (addr & mask) == base
  localparam logic [ADDR_W-1:0] REGION_BASE [NUM_REGIONS] =
    '{20'h00000, 20'hC0000, 20'h80000, 20'h90000};
  localparam logic [ADDR_W-1:0] REGION_MASK [NUM_REGIONS] =
    '{20'h80000, 20'hC0000, 20'hF0000, 20'hF0000};

  // which regions accept a write enable (ROM excluded)
  localparam logic [NUM_REGIONS-1:0] REGION_WRITABLE = 4'b1101;

  // strobes from control to datapath
  typedef struct packed {
    logic ledLoad;
  } dpStrobe_t;

endpackage

// File: rtl/glue_ctrl.sv
module glue_ctrl
  import glue_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [AW-1:0]          addr,
  input  logic                   asN,
  input  logic                   dsN,
  input  logic                   rdWr,
  input  logic [2:0]             fc,
  output logic [NUM_REGIONS-1:0] csVec,
  output logic                   readEnN,
  output logic                   writeEnN,
  output dpStrobe_t              strobe
);

  logic                   cycleValid;
  logic [NUM_REGIONS-1:0] regionHit;
  logic                   anySel;
  logic                   writableSel;

  assign cycleValid = !asN && (fc != FC_INTACK);

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    assign regionHit[i] = ((addr & REGION_MASK[i]) == REGION_BASE[i]);
    assign csVec[i]     = regionHit[i] && cycleValid;
  end

  assign anySel      = |csVec;
  assign writableSel = |(csVec & REGION_WRITABLE);

  always_comb begin
    readEnN        = !(rdWr && !dsN && anySel);
    writeEnN       = !(!rdWr && !dsN && writableSel);
    strobe.ledLoad = csVec[RGN_LED] && !rdWr && !dsN;
  end

  assert_idle_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    asN |-> (csVec == '0));

  assert_intack_block_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fc == FC_INTACK) |-> (csVec == '0));

  assert_one_select_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(csVec));

  assert_read_qual_R7: assert property (@(posedge clk) disable iff (!rstN)
    !readEnN |-> (rdWr && !dsN && !asN));

  assert_rom_nowrite_R8: assert property (@(posedge clk) disable iff (!rstN)
    csVec[RGN_ROM] |-> writeEnN);

endmodule

// File: rtl/glue_led.sv
module glue_led
  import glue_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] ledOut
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ledOut <= '0;
    else if (strobe.ledLoad) ledOut <= dataIn;
  end

  assert_led_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ledLoad |=> (ledOut == $past(dataIn)));

  assert_led_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ledLoad |=> $stable(ledOut));

endmodule

// File: rtl/cpu_glue.sv
module cpu_glue
  import glue_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              asN,
  input  logic              dsN,
  input  logic              rdWr,
  input  logic [2:0]        fc,
  input  logic [DATA_W-1:0] dataIn,
  output logic              romCsN,
  output logic              ramCsN,
  output logic              serCsN,
  output logic              ledCsN,
  output logic              readEnN,
  output logic              writeEnN,
  output logic              dtackN,
  output logic [2:0]        iplN,
  output logic [DATA_W-1:0] ledOut
);

  logic [NUM_REGIONS-1:0] csVec;
  dpStrobe_t              strobe;

  glue_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .asN      (asN),
    .dsN      (dsN),
    .rdWr     (rdWr),
    .fc       (fc),
    .csVec    (csVec),
    .readEnN  (readEnN),
    .writeEnN (writeEnN),
    .strobe   (strobe)
  );

  glue_led #(.DW(DATA_W)) u_led (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .dataIn (dataIn),
    .ledOut (ledOut)
  );

  assign ramCsN = !csVec[RGN_RAM];
  assign romCsN = !csVec[RGN_ROM];
  assign serCsN = !csVec[RGN_SER];
  assign ledCsN = !csVec[RGN_LED];

  // every access completes with no wait states; no interrupts are requested
  assign dtackN = 1'b0;
  assign iplN   = 3'b111;

  assert_led_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!ledCsN && !rdWr && !dsN) |=> (ledOut == $past(dataIn)));

endmodule

// File: tb/cpu_glue_bench.sv
module cpu_glue_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] addr = '0;
  logic        asN = 1'b1;
  logic        dsN = 1'b1;
  logic        rdWr = 1'b1;
  logic [2:0]  fc = 3'b101;
  logic [7:0]  dataIn = '0;
  logic romCsN, ramCsN, serCsN, ledCsN, readEnN, writeEnN, dtackN;
  logic [2:0]  iplN;
  logic [7:0]  ledOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [7:0] expLed = '0;

  cpu_glue u_cpu_glue (
    .clk(clk), .rstN(rstN), .addr(addr), .asN(asN), .dsN(dsN), .rdWr(rdWr),
    .fc(fc), .dataIn(dataIn), .romCsN(romCsN), .ramCsN(ramCsN),
    .serCsN(serCsN), .ledCsN(ledCsN), .readEnN(readEnN), .writeEnN(writeEnN),
    .dtackN(dtackN), .iplN(iplN), .ledOut(ledOut)
  );

  always #10 clk = ~clk;

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
      finishRun();
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one bus combination, check combinational outputs and the LED edge
  task automatic busCycle(logic [19:0] a, logic as, logic ds, logic rw,
                          logic [2:0] f, logic [7:0] d);
    logic [3:0] nib;
    logic valid, ram, rom, ser, led, anySel, rdE, wrE, ledWr;
    logic [10:0] expVec, actVec;
    @(negedge clk);
    addr = a; asN = as; dsN = ds; rdWr = rw; fc = f; dataIn = d;
    nib    = a[19:16];
    valid  = !as && (f != 3'd7);
    ram    = valid && (nib < 4'd8);
    rom    = valid && (nib >= 4'd12);
    ser    = valid && (nib == 4'd8);
    led    = valid && (nib == 4'd9);
    anySel = ram || rom || ser || led;
    rdE    = rw && !ds && anySel;
    wrE    = !rw && !ds && (ram || ser || led);
    ledWr  = led && !rw && !ds;
    expVec = {!rom, !ram, !ser, !led, !rdE, !wrE, 1'b0, 3'b111, 1'b0};
    #3;
    actVec = {romCsN, ramCsN, serCsN, ledCsN, readEnN, writeEnN, dtackN, iplN, 1'b0};
    check("R1 R2 R3 R4 R5 R6 R7 R8 R9 decode", 32'(actVec), 32'(expVec));
    if (ledWr) expLed = d;
    @(posedge clk);
    #3;
    check("R10 led register", 32'(ledOut), 32'(expLed));
  endtask

  initial begin
    // R11: reset state
    #5;
    check("R11 reset clear", 32'(ledOut), 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // exhaustive sweep over nibble, strobes, direction and function code
    for (int i = 0; i < 1024; i++) begin
      logic [3:0]  n;
      logic [19:0] a;
      n = 4'(i >> 6);
      a = {n, 16'(i * 2731 + 17)};
      busCycle(a, i[0], i[1], i[2], 3'(i >> 3), 8'(i * 13 + 5));
    end

    // R8: ROM-region write with every strobe asserted
    busCycle(20'hC1234, 1'b0, 1'b0, 1'b0, 3'b101, 8'hEE);
    check("R8 rom write enable", 32'(writeEnN), 32'h1);

    // R10: back-to-back LED writes, then a read of the same region holds
    busCycle(20'h9FFFF, 1'b0, 1'b0, 1'b0, 3'b001, 8'hA5);
    busCycle(20'h90000, 1'b0, 1'b0, 1'b0, 3'b001, 8'h3C);
    busCycle(20'h90000, 1'b0, 1'b0, 1'b1, 3'b001, 8'hFF);
    check("R10 hold after read", 32'(ledOut), 32'h3C);

    // R4: boundary addresses with the address strobe idle
    busCycle(20'hFFFFF, 1'b1, 1'b0, 1'b0, 3'b101, 8'h11);
    busCycle(20'h7FFFF, 1'b1, 1'b0, 1'b1, 3'b101, 8'h22);

    // R11: reset after the register holds a nonzero value
    @(negedge clk);
    rstN = 1'b0;
    #3;
    check("R11 reset clears loaded value", 32'(ledOut), 32'h0);
    expLed = '0;
    @(negedge clk);
    rstN = 1'b1;
    busCycle(20'h95555, 1'b0, 1'b1, 1'b0, 3'b101, 8'h77);
    check("R10 no load without data strobe", 32'(ledOut), 32'h0);

    finishRun();
  end

endmodule